// File: doc/BRIEF.md
# Line Parity Error Tally and Signal-Degrade Detector

This block sits behind the line-overhead parity checker of a receive framer. Once per frame it takes a vector of mismatch bits, one for each bit of the line parity bytes, together with a one-cycle frame strobe. It turns that vector into a per-frame error increment. The increment counts either every wrong bit or at most one error per frame, as configured. The increment feeds a saturating accumulated error counter and a signal-degrade detector.

The detector divides a programmable monitoring window, measured in frames, into eight equal sub-intervals and keeps one counter per sub-interval in a ring. Each counter saturates at a programmable burst limit, so a short error burst cannot on its own push the detector over the threshold. When a new sub-interval starts, the oldest counter is reused and cleared, which makes the window slide. The degrade flag is raised on the frame at which the windowed sum reaches the set threshold. It drops when a full window ends with the sum below a separate clear threshold.

Top module: `lpe_degrade_mon`

## Requirements
- R1: With `perFrameMode` = 0, `frameInc` equals the number of set bits among the active parity bits of the frame. It is registered on the clock edge that samples `frameStb`.
- R2: With `perFrameMode` = 1, `frameInc` is 1 if any active parity bit is set and 0 otherwise.
- R3: With `wideMode` = 0, only `parityErr[23:0]` (3 bytes) are active and bits 24 and up are ignored. With `wideMode` = 1, all 96 bits (12 bytes) are active.
- R4: `errCount` resets to 0 and adds `frameInc` on every frame strobe, whether or not detection is enabled. It holds its value between strobes and saturates at all ones.
- R5: `degradeFlag` rises on the edge of the frame strobe at which the windowed sum of sub-interval counters reaches `setThresh` or more.
- R6: Each sub-interval counter is limited to `burstLimit`, however many errors arrive within that sub-interval.
- R7: A sub-interval lasts `windowLen >> 3` frames, with a minimum of 1. Eight sub-intervals form the window. Entering a new sub-interval discards the oldest sub-interval's contribution.
- R8: `degradeFlag` falls only on the frame that completes the eighth sub-interval of a window, and only if the windowed sum is then below `clrThresh`.
- R9: With `detectEn` low, errors are ignored by the detector. Lowering `detectEn`, or changing `windowLen`, clears every sub-interval counter and drops `degradeFlag` on the next clock edge.
- R10: After reset `frameInc`, `errCount` and `degradeFlag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle strobe marking a frame's parity result |
| parityErr | input | 96 | Parity mismatch bits, byte 0 in bits 7:0 |
| wideMode | input | 1 | 1: 12 parity bytes active, 0: 3 bytes active |
| perFrameMode | input | 1 | 1: at most one error per frame, 0: one per wrong bit |
| detectEn | input | 1 | Enables the degrade detector |
| windowLen | input | 16 | Monitoring window length in frames |
| burstLimit | input | 16 | Cap on each sub-interval counter |
| setThresh | input | 16 | Windowed sum that declares degrade |
| clrThresh | input | 16 | Windowed sum below which degrade clears at window end |
| frameInc | output | 7 | Error increment of the latest frame |
| errCount | output | 24 | Saturating accumulated error count |
| degradeFlag | output | 1 | Signal-degrade defect |

## Verification
Assertions check, on every cycle, the properties that hold whatever the stimulus:
- in per-frame mode the increment is never above one;
- the error count never falls and stays steady between strobes;
- every sub-interval counter stays at or below the burst limit after it is updated;
- the flag rises only on a strobe;
- the flag falls only on a flush or at a window end;
- a disabled detector holds the flag low.

The exact cycle arithmetic can only be shown by the directed scenarios. These cover:
- the bit counts under both byte widths;
- the frame on which the capped sub-interval sums first reach the threshold;
- the frame on which a sliding window has drained enough to clear the flag;
- counter saturation;
- the flush caused by a change of window length.

// File: rtl/lpe_pkg.sv
package lpe_pkg;
  parameter int SLOT_COUNT = 8;
  localparam int SLOT_IDX_W = $clog2(SLOT_COUNT);

  // Strobes from window control to the datapath.
  typedef struct packed {
    logic                  flush;
    logic                  accum;
    logic                  advance;
    logic [SLOT_IDX_W-1:0] ptr;
  } winCtl_t;
endpackage

// File: rtl/lpe_tally_dp.sv
module lpe_tally_dp
  import lpe_pkg::*;
#(
  parameter int MAX_BYTES   = 12,
  parameter int SHORT_BYTES = 3,
  parameter int CNT_W       = 24,
  parameter int SLOT_W      = 16,
  localparam int MASK_W     = MAX_BYTES * 8,
  localparam int SHORT_W    = SHORT_BYTES * 8,
  localparam int INC_W      = $clog2(MASK_W + 1),
  localparam int SUM_W      = SLOT_W + SLOT_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [MASK_W-1:0] parityErr,
  input  logic              wideMode,
  input  logic              perFrameMode,
  input  logic [SLOT_W-1:0] burstLimit,
  input  winCtl_t           ctl,
  output logic [INC_W-1:0]  frameInc,
  output logic [CNT_W-1:0]  errCount,
  output logic [SUM_W-1:0]  sumNext
);

  logic [MASK_W-1:0] activeMask;
  logic [INC_W-1:0]  bitTally;
  logic [INC_W-1:0]  incNow;
  logic [CNT_W:0]    cntSum;
  logic [SLOT_W:0]   slotSum;
  logic [SLOT_W-1:0] slotCapped;
  logic [SLOT_IDX_W-1:0] nextIdx;
  logic [SLOT_W-1:0] slotQ [SLOT_COUNT];
  logic [INC_W-1:0]  frameIncQ;
  logic [CNT_W-1:0]  errCountQ;

  // Active parity bits for the selected byte count.
  always_comb begin
    activeMask = parityErr;
    if (!wideMode) activeMask = {{(MASK_W - SHORT_W){1'b0}}, parityErr[SHORT_W-1:0]};
  end

  always_comb begin
    bitTally = '0;
    for (int i = 0; i < MASK_W; i++) bitTally = bitTally + INC_W'(activeMask[i]);
  end

  assign incNow = perFrameMode ? INC_W'(|activeMask) : bitTally;

  // Accumulated counter with saturation.
  assign cntSum = {1'b0, errCountQ} + (CNT_W + 1)'(incNow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameIncQ <= '0;
      errCountQ <= '0;
    end else if (frameStb) begin
      frameIncQ <= incNow;
      errCountQ <= cntSum[CNT_W] ? '1 : cntSum[CNT_W-1:0];
    end
  end

  assign frameInc = frameIncQ;
  assign errCount = errCountQ;

  // Current sub-interval update, clipped at the burst limit.
  assign slotSum    = {1'b0, slotQ[ctl.ptr]} + (SLOT_W + 1)'(incNow);
  assign slotCapped = (slotSum > {1'b0, burstLimit}) ? burstLimit : slotSum[SLOT_W-1:0];
  assign nextIdx    = (ctl.ptr == SLOT_IDX_W'(SLOT_COUNT - 1)) ? '0 : ctl.ptr + 1'b1;

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN || ctl.flush) begin
        slotQ[s] <= '0;
      end else if (ctl.accum && ctl.ptr == SLOT_IDX_W'(s)) begin
        slotQ[s] <= slotCapped;
      end else if (ctl.advance && nextIdx == SLOT_IDX_W'(s)) begin
        slotQ[s] <= '0;
      end
    end

    // R6: an updated slot never exceeds the burst limit of its update cycle
    a_r6_slot_capped: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.accum && ctl.ptr == SLOT_IDX_W'(s)) |=> (slotQ[s] <= $past(burstLimit)));
  end

  // Windowed sum including this frame's contribution.
  always_comb begin
    sumNext = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      if (ctl.accum && ctl.ptr == SLOT_IDX_W'(i)) sumNext = sumNext + SUM_W'(slotCapped);
      else                                        sumNext = sumNext + SUM_W'(slotQ[i]);
    end
  end

  // R2: per-frame mode yields at most one error
  a_r2_single_per_frame: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && perFrameMode) |=> (frameIncQ <= INC_W'(1)));

  // R4: count never decreases across a frame
  a_r4_count_nondecreasing: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |=> (errCountQ >= $past(errCountQ)));

  // R4: count holds between strobes
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> $stable(errCountQ));

endmodule

// File: rtl/lpe_window_ctl.sv
module lpe_window_ctl
  import lpe_pkg::*;
#(
  parameter int WIN_W  = 16,
  parameter int THR_W  = 16,
  parameter int SUM_W  = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStb,
  input  logic             detectEn,
  input  logic [WIN_W-1:0] windowLen,
  input  logic [THR_W-1:0] setThresh,
  input  logic [THR_W-1:0] clrThresh,
  input  logic [SUM_W-1:0] sumNext,
  output winCtl_t          ctl,
  output logic             degradeFlag
);

  logic [WIN_W-1:0]      winLenQ;
  logic [WIN_W-1:0]      subLen;
  logic [WIN_W-1:0]      subLast;
  logic [WIN_W-1:0]      subCntQ;
  logic [SLOT_IDX_W-1:0] ptrQ;
  logic                  flagQ;
  logic                  flush;
  logic                  accum;
  logic                  advance;
  logic                  windowEnd;
  logic                  reachSet;
  logic                  belowClr;

  always_comb begin
    subLen    = windowLen >> SLOT_IDX_W;
    subLast   = (subLen > WIN_W'(1)) ? subLen - 1'b1 : '0;
    flush     = !detectEn || (windowLen != winLenQ);
    accum     = frameStb && !flush;
    advance   = accum && (subCntQ >= subLast);
    windowEnd = advance && (ptrQ == SLOT_IDX_W'(SLOT_COUNT - 1));
    reachSet  = (sumNext >= SUM_W'(setThresh));
    belowClr  = (sumNext <  SUM_W'(clrThresh));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winLenQ <= '0;
      subCntQ <= '0;
      ptrQ    <= '0;
      flagQ   <= 1'b0;
    end else begin
      winLenQ <= windowLen;
      if (flush) begin
        subCntQ <= '0;
        ptrQ    <= '0;
        flagQ   <= 1'b0;
      end else if (accum) begin
        subCntQ <= advance ? '0 : subCntQ + 1'b1;
        if (advance) ptrQ <= (ptrQ == SLOT_IDX_W'(SLOT_COUNT - 1)) ? '0 : ptrQ + 1'b1;
        if (reachSet)                   flagQ <= 1'b1;
        else if (windowEnd && belowClr) flagQ <= 1'b0;
      end
    end
  end

  assign ctl.flush   = flush;
  assign ctl.accum   = accum;
  assign ctl.advance = advance;
  assign ctl.ptr     = ptrQ;
  assign degradeFlag = flagQ;

  // R5: the flag rises only on a frame strobe
  a_r5_rise_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(frameStb));

  // R8: the flag falls only at a window end or on a flush
  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> ($past(windowEnd) || $past(flush)));

  // R9: a disabled detector drops the flag on the next edge
  a_r9_disable_drops: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |=> !flagQ);

endmodule

// File: rtl/lpe_degrade_mon.sv
module lpe_degrade_mon
  import lpe_pkg::*;
#(
  parameter int MAX_BYTES   = 12,
  parameter int SHORT_BYTES = 3,
  parameter int CNT_W       = 24,
  parameter int SLOT_W      = 16,
  parameter int WIN_W       = 16,
  parameter int THR_W       = 16,
  localparam int MASK_W     = MAX_BYTES * 8,
  localparam int INC_W      = $clog2(MASK_W + 1),
  localparam int SUM_W      = SLOT_W + SLOT_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [MASK_W-1:0] parityErr,
  input  logic              wideMode,
  input  logic              perFrameMode,
  input  logic              detectEn,
  input  logic [WIN_W-1:0]  windowLen,
  input  logic [SLOT_W-1:0] burstLimit,
  input  logic [THR_W-1:0]  setThresh,
  input  logic [THR_W-1:0]  clrThresh,
  output logic [INC_W-1:0]  frameInc,
  output logic [CNT_W-1:0]  errCount,
  output logic              degradeFlag
);

  winCtl_t          ctl;
  logic [SUM_W-1:0] sumNext;

  lpe_tally_dp #(
    .MAX_BYTES  (MAX_BYTES),
    .SHORT_BYTES(SHORT_BYTES),
    .CNT_W      (CNT_W),
    .SLOT_W     (SLOT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .frameStb    (frameStb),
    .parityErr   (parityErr),
    .wideMode    (wideMode),
    .perFrameMode(perFrameMode),
    .burstLimit  (burstLimit),
    .ctl         (ctl),
    .frameInc    (frameInc),
    .errCount    (errCount),
    .sumNext     (sumNext)
  );

  lpe_window_ctl #(
    .WIN_W(WIN_W),
    .THR_W(THR_W),
    .SUM_W(SUM_W)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStb   (frameStb),
    .detectEn   (detectEn),
    .windowLen  (windowLen),
    .setThresh  (setThresh),
    .clrThresh  (clrThresh),
    .sumNext    (sumNext),
    .ctl        (ctl),
    .degradeFlag(degradeFlag)
  );

endmodule

// File: tb/lpe_degrade_mon_bench.sv
`timescale 1ns/1ps
module lpe_degrade_mon_bench;
  localparam int CNT_W = 10;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStb = 1'b0;
  logic [95:0] parityErr = '0;
  logic        wideMode = 1'b1;
  logic        perFrameMode = 1'b0;
  logic        detectEn = 1'b0;
  logic [15:0] windowLen = 16'd16;
  logic [15:0] burstLimit = 16'd5;
  logic [15:0] setThresh = 16'd20;
  logic [15:0] clrThresh = 16'd4;
  logic [6:0]  frameInc;
  logic [CNT_W-1:0] errCount;
  logic        degradeFlag;

  int checkCnt = 0;
  int failCnt = 0;
  int expCount = 0;
  bit finished = 1'b0;

  lpe_degrade_mon #(.CNT_W(CNT_W)) u_lpe_degrade_mon (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .parityErr(parityErr),
    .wideMode(wideMode), .perFrameMode(perFrameMode), .detectEn(detectEn),
    .windowLen(windowLen), .burstLimit(burstLimit), .setThresh(setThresh),
    .clrThresh(clrThresh), .frameInc(frameInc), .errCount(errCount),
    .degradeFlag(degradeFlag)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checkCnt++;
    if (actual != expected) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int modelInc(input logic [95:0] m, input bit wide, input bit perFrame);
    int n = 0;
    int top = wide ? 96 : 24;
    for (int i = 0; i < top; i++) n += m[i];
    if (perFrame) return (n != 0) ? 1 : 0;
    return n;
  endfunction

  // One frame: strobe for a cycle, outputs settle before return.
  task automatic sendFrame(input logic [95:0] m);
    @(negedge clk);
    frameStb = 1'b1;
    parityErr = m;
    expCount += modelInc(m, wideMode, perFrameMode);
    if (expCount > CNT_MAX) expCount = CNT_MAX;
    @(negedge clk);
    frameStb = 1'b0;
    parityErr = '0;
  endtask

  task automatic flushWindow();
    @(negedge clk); detectEn = 1'b0;
    @(negedge clk);
    @(negedge clk); detectEn = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 frameInc", frameInc, 0);
    check("R10 errCount", errCount, 0);
    check("R10 degradeFlag", degradeFlag, 0);
  endtask

  task automatic testPerBit();
    perFrameMode = 1'b0;
    wideMode = 1'b1;
    sendFrame('1);
    check("R1 wide all bits", frameInc, 96);
    sendFrame(96'h5);
    check("R1 two bits", frameInc, 2);
    check("R4 running count", errCount, expCount);
    wideMode = 1'b0;
    sendFrame('1);
    check("R3 narrow all bits", frameInc, 24);
    sendFrame({72'hFFFF_FFFF_FFFF_FFFF_FF, 24'h0});
    check("R3 high bits ignored", frameInc, 0);
    sendFrame({72'h1, 24'h80_0001});
    check("R3 narrow partial", frameInc, 2);
    wideMode = 1'b1;
  endtask

  task automatic testPerFrame();
    perFrameMode = 1'b1;
    sendFrame('1);
    check("R2 many errors", frameInc, 1);
    sendFrame('0);
    check("R2 clean frame", frameInc, 0);
    sendFrame(96'h1 << 95);
    check("R2 top bit only", frameInc, 1);
    check("R4 count per-frame", errCount, expCount);
    repeat (3) @(negedge clk);
    check("R4 hold idle", errCount, expCount);
    perFrameMode = 1'b0;
  endtask

  task automatic testSaturation();
    for (int i = 0; i < 12; i++) sendFrame('1);
    check("R4 saturated", errCount, CNT_MAX);
    sendFrame('1);
    check("R4 stays saturated", errCount, CNT_MAX);
  endtask

  task automatic testSetClear();
    windowLen = 16'd16;
    flushWindow();
    for (int k = 1; k <= 7; k++) begin
      sendFrame('1);
      check((k == 7) ? "R5 set at threshold" : "R6 capped below threshold",
            degradeFlag, (k >= 7) ? 1 : 0);
    end
    for (int k = 8; k <= 32; k++) begin
      sendFrame('0);
      if (k == 16 || k == 20 || k == 31)
        check("R7 still degraded mid-slide", degradeFlag, 1);
      if (k == 32) check("R8 clear at window end", degradeFlag, 0);
    end
  endtask

  task automatic testLenChange();
    flushWindow();
    for (int k = 1; k <= 7; k++) sendFrame('1);
    check("R5 set again", degradeFlag, 1);
    @(negedge clk); windowLen = 16'd24;
    @(negedge clk);
    check("R9 window change clears", degradeFlag, 0);
    for (int k = 1; k <= 10; k++) begin
      sendFrame('1);
      if (k == 9)  check("R7 three-frame sub-interval", degradeFlag, 0);
      if (k == 10) check("R7 set on tenth frame", degradeFlag, 1);
    end
  endtask

  task automatic testDisable();
    @(negedge clk); detectEn = 1'b0;
    @(negedge clk);
    check("R9 disable clears", degradeFlag, 0);
    for (int k = 0; k < 12; k++) sendFrame('1);
    check("R9 ignored while off", degradeFlag, 0);
    @(negedge clk); detectEn = 1'b1;
    @(negedge clk);
    sendFrame('1);
    check("R9 window empty after enable", degradeFlag, 0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPerBit();
    testPerFrame();
    testSaturation();
    testSetClear();
    testLenChange();
    testDisable();
    finished = 1'b1;
    finishRun();
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual running expected done");
      finishRun();
    end
  end

endmodule